// File: doc/BRIEF.md
# Taken-Branch Target Cache Predictor

This block sits next to instruction fetch and guesses, in the same cycle, where fetch goes next. It keeps a small fully associative set of branches that were taken when they last resolved, each with its target address. Every cycle the fetch address is compared against all stored keys at once. A hit means "taken": the stored target is offered as the next fetch address. A miss means sequential fetch, so the next address is the fetch address plus one instruction.

Each entry's key is the address of the instruction just before the branch, which is the branch address minus the instruction size. The target is therefore known one fetch earlier than the branch, and the redirect costs no cycles. When a branch resolves in execute, an update port gives its address, outcome, actual target and the prediction that was made for it. The block then allocates, refreshes or drops an entry. One cycle later it raises a mispredict pulse with the corrected fetch address whenever the prediction was wrong. When all entries are valid and a new branch must be stored, the least recently used entry is replaced.

Top module: `btac_predictor`

## Requirements
- R1: After reset no entry is valid: every lookup misses and `pred_next` equals `fetch_addr + INSTR_BYTES`.
- R2: A lookup hits when `fetch_addr` equals (branch address − `INSTR_BYTES`) of a valid entry. `pred_next` is then that entry's stored target. A lookup at the branch's own address does not match that entry.
- R3: On a miss `pred_hit` is 0 and `pred_next` is `fetch_addr + INSTR_BYTES` (4 by default).
- R4: An update with `upd_taken`=1 for a branch that has no entry creates one holding the branch key and `upd_target`.
- R5: An update with `upd_taken`=0 never creates an entry.
- R6: An update with `upd_taken`=0 for a branch that has an entry clears that entry, so later lookups at its key miss.
- R7: An update with `upd_taken`=1 for a branch that already has an entry replaces its target in place. Later lookups return the new target, and no second entry is made.
- R8: Taken updates (allocation or refresh) mark an entry most recently used. A new allocation fills an invalid entry if one exists. Otherwise it evicts the entry whose last taken update is oldest.
- R9: When an update and a lookup fall in the same cycle, the lookup sees the contents the update produces.
- R10: In the cycle after an update, `mispredict` is 1 exactly when `upd_taken` ≠ `upd_pred_taken`, or when both are 1 and `upd_target` ≠ `upd_pred_target`. With the pulse, `redirect_addr` is `upd_target` if taken, else `upd_pc + INSTR_BYTES`. Without an update the pulse stays low.
- R11: At most one valid entry matches any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | ADDR_W | Current fetch address to look up |
| pred_hit | output | 1 | Lookup hit, meaning taken predicted |
| pred_next | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | ADDR_W | Resolved target address |
| upd_pred_taken | input | 1 | Outcome that was predicted for this branch |
| upd_pred_target | input | ADDR_W | Target that was predicted for this branch |
| mispredict | output | 1 | One-cycle pulse: the prediction was wrong |
| redirect_addr | output | ADDR_W | Corrected fetch address, valid with `mispredict` |

## Verification
The hardest state to reach is replacement with a full cache whose recency order has been reshuffled by refreshes and by invalidations that leave holes. A victim choice there is wrong only if the wrong entry gets evicted. The bench uses a four-entry configuration and drives eight distinct branches through a long pseudo-random series of taken, not-taken and retargeting resolutions. This keeps the cache overflowing and punching holes. After every update it probes all eight keys against an ordered recency list kept in the bench. Directed steps also put an update and a lookup of the same key in one cycle, and feed deliberately wrong predictions.

// File: rtl/btac_pkg.sv
package btac_pkg;

   // What a resolved branch does to the entry array.
   typedef enum logic [1:0] {
      ACT_NONE    = 2'd0,
      ACT_ALLOC   = 2'd1,
      ACT_REFRESH = 2'd2,
      ACT_DROP    = 2'd3
   } btac_act_e;

endpackage

// File: rtl/btac_cam.sv
module btac_cam #(
   parameter int N  = 8,
   parameter int KW = 32
) (
   input  logic [N-1:0]         valid,
   input  logic [N-1:0][KW-1:0] keys,
   input  logic [KW-1:0]        probe,
   output logic [N-1:0]         match
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = valid[g] && (keys[g] == probe);
   end

endmodule

// File: rtl/btac_lru.sv
module btac_lru #(
   parameter int N = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 touch,
   input  logic [$clog2(N)-1:0] touch_idx,
   input  logic [N-1:0]         valid,
   output logic [$clog2(N)-1:0] victim_idx
);

   localparam int AW = $clog2(N);
   localparam logic [AW-1:0] OLDEST = AW'(N - 1);

   logic [N-1:0][AW-1:0] age_q;
   logic                 hole_found;

   // An invalid entry is preferred; otherwise the oldest one.
   always_comb begin
      victim_idx = '0;
      hole_found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!valid[i] && !hole_found) begin
            victim_idx = AW'(i);
            hole_found = 1'b1;
         end
      end
      if (!hole_found) begin
         for (int i = 0; i < N; i++) begin
            if (age_q[i] == OLDEST) victim_idx = AW'(i);
         end
      end
   end

   // Ages form a permutation of 0..N-1; 0 is most recent.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (AW'(i) == touch_idx)             age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

endmodule

// File: rtl/btac_next_addr.sv
module btac_next_addr #(
   parameter int N      = 8,
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic [N-1:0]             match,
   input  logic [N-1:0][ADDR_W-1:0] targets,
   input  logic [ADDR_W-1:0]        fetch_addr,
   output logic                     hit,
   output logic [ADDR_W-1:0]        next_addr
);

   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

   logic [ADDR_W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) picked = picked | targets[i];
      end
   end

   assign hit       = |match;
   assign next_addr = hit ? picked : fetch_addr + STEP_A;

endmodule

// File: rtl/btac_predictor.sv
module btac_predictor
   import btac_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ENTRIES     = 8,
   parameter int INSTR_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              pred_hit,
   output logic [ADDR_W-1:0] pred_next,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              upd_pred_taken,
   input  logic [ADDR_W-1:0] upd_pred_target,
   output logic              mispredict,
   output logic [ADDR_W-1:0] redirect_addr
);

   localparam int IW = $clog2(ENTRIES);
   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(INSTR_BYTES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("btac_predictor: ENTRIES must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_width
      $error("btac_predictor: ADDR_W must be at least 8");
   end
   if (INSTR_BYTES < 1) begin : g_bad_step
      $error("btac_predictor: INSTR_BYTES must be positive");
   end

   // Entry storage
   logic [ENTRIES-1:0]             valid_q, valid_d;
   logic [ENTRIES-1:0][ADDR_W-1:0] key_q, key_d;
   logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q, tgt_d;

   // Update path
   logic [ADDR_W-1:0]  upd_key;
   logic [ENTRIES-1:0] upd_match;
   logic               upd_hit;
   logic [IW-1:0]      upd_idx;
   logic [IW-1:0]      victim_idx;
   logic [IW-1:0]      wr_idx;
   btac_act_e          act;

   // Lookup path
   logic [ENTRIES-1:0] look_match;

   assign upd_key = upd_pc - STEP_A;

   btac_cam #(.N(ENTRIES), .KW(ADDR_W)) i_upd_cam (
      .valid (valid_q),
      .keys  (key_q),
      .probe (upd_key),
      .match (upd_match)
   );

   assign upd_hit = |upd_match;

   always_comb begin
      upd_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (upd_match[i]) upd_idx = IW'(i);
      end
   end

   always_comb begin
      act = ACT_NONE;
      if (upd_valid) begin
         if (upd_taken) act = upd_hit ? ACT_REFRESH : ACT_ALLOC;
         else if (upd_hit) act = ACT_DROP;
      end
   end

   assign wr_idx = (act == ACT_ALLOC) ? victim_idx : upd_idx;

   btac_lru #(.N(ENTRIES)) i_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      ((act == ACT_ALLOC) || (act == ACT_REFRESH)),
      .touch_idx  (wr_idx),
      .valid      (valid_q),
      .victim_idx (victim_idx)
   );

   always_comb begin
      valid_d = valid_q;
      key_d   = key_q;
      tgt_d   = tgt_q;
      unique case (act)
         ACT_ALLOC: begin
            valid_d[wr_idx] = 1'b1;
            key_d[wr_idx]   = upd_key;
            tgt_d[wr_idx]   = upd_target;
         end
         ACT_REFRESH: tgt_d[wr_idx]   = upd_target;
         ACT_DROP:    valid_d[wr_idx] = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         key_q   <= '0;
         tgt_q   <= '0;
      end else begin
         valid_q <= valid_d;
         key_q   <= key_d;
         tgt_q   <= tgt_d;
      end
   end

   // Lookup against post-update contents so a same-cycle write is seen.
   btac_cam #(.N(ENTRIES), .KW(ADDR_W)) i_look_cam (
      .valid (valid_d),
      .keys  (key_d),
      .probe (fetch_addr),
      .match (look_match)
   );

   btac_next_addr #(.N(ENTRIES), .ADDR_W(ADDR_W), .STEP(INSTR_BYTES)) i_next (
      .match      (look_match),
      .targets    (tgt_d),
      .fetch_addr (fetch_addr),
      .hit        (pred_hit),
      .next_addr  (pred_next)
   );

   // Misprediction report, one cycle after resolution
   logic              wrong_dir, wrong_tgt;
   logic              mis_q;
   logic [ADDR_W-1:0] redir_q;

   assign wrong_dir = upd_taken != upd_pred_taken;
   assign wrong_tgt = upd_taken && upd_pred_taken && (upd_target != upd_pred_target);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mis_q   <= 1'b0;
         redir_q <= '0;
      end else begin
         mis_q <= upd_valid && (wrong_dir || wrong_tgt);
         if (upd_valid) redir_q <= upd_taken ? upd_target : upd_pc + STEP_A;
      end
   end

   assign mispredict    = mis_q;
   assign redirect_addr = redir_q;

endmodule

// File: rtl/btac_checker.sv
module btac_checker #(
   parameter int ADDR_W      = 32,
   parameter int ENTRIES     = 8,
   parameter int INSTR_BYTES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               upd_valid,
   input logic [ADDR_W-1:0]  upd_pc,
   input logic               upd_taken,
   input logic [ADDR_W-1:0]  upd_target,
   input logic               upd_pred_taken,
   input logic               mispredict,
   input logic [ADDR_W-1:0]  redirect_addr,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] look_match
);

   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(INSTR_BYTES);

   assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_match));

   assert_no_alloc_on_fallthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=> ($countones(valid_q) <= $countones($past(valid_q))));

   assert_taken_leaves_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=> (valid_q != '0));

   assert_dir_mismatch_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && (upd_taken != upd_pred_taken)) |=> mispredict);

   assert_quiet_without_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> !mispredict);

   assert_redirect_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=> (redirect_addr == $past(upd_target)));

   assert_redirect_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=> (redirect_addr == $past(upd_pc) + STEP_A));

endmodule

bind btac_predictor btac_checker #(
   .ADDR_W      (ADDR_W),
   .ENTRIES     (ENTRIES),
   .INSTR_BYTES (INSTR_BYTES)
) i_btac_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .upd_valid      (upd_valid),
   .upd_pc         (upd_pc),
   .upd_taken      (upd_taken),
   .upd_target     (upd_target),
   .upd_pred_taken (upd_pred_taken),
   .mispredict     (mispredict),
   .redirect_addr  (redirect_addr),
   .valid_q        (valid_q),
   .look_match     (look_match)
);

// File: tb/test_btac_predictor.sv
module test_btac_predictor;

   localparam int AW = 32;
   localparam int NE = 4;
   localparam int NB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          pred_hit;
   logic [AW-1:0] pred_next;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_pc = '0;
   logic          upd_taken = 1'b0;
   logic [AW-1:0] upd_target = '0;
   logic          upd_pred_taken = 1'b0;
   logic [AW-1:0] upd_pred_target = '0;
   logic          mispredict;
   logic [AW-1:0] redirect_addr;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   btac_predictor #(.ADDR_W(AW), .ENTRIES(NE), .INSTR_BYTES(4)) i_btac_predictor (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
      .pred_hit(pred_hit), .pred_next(pred_next),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target), .upd_pred_taken(upd_pred_taken),
      .upd_pred_target(upd_pred_target),
      .mispredict(mispredict), .redirect_addr(redirect_addr)
   );

   // Reference: recency-ordered list, index 0 is most recent.
   logic [AW-1:0] m_pc  [NE];
   logic [AW-1:0] m_tgt [NE];
   int            m_cnt = 0;

   function automatic logic [AW-1:0] pc_of(int b);
      return 32'h0000_1000 + 32'(b) * 32'h40;
   endfunction

   function automatic logic [AW-1:0] tgt_of(int b, int v);
      return 32'h0008_0000 + 32'(b) * 32'h100 + 32'(v) * 32'h8;
   endfunction

   function automatic int m_find(logic [AW-1:0] pc);
      for (int i = 0; i < m_cnt; i++) if (m_pc[i] == pc) return i;
      return -1;
   endfunction

   task automatic m_remove(int at);
      for (int i = at; i < m_cnt - 1; i++) begin
         m_pc[i]  = m_pc[i+1];
         m_tgt[i] = m_tgt[i+1];
      end
      m_cnt--;
   endtask

   task automatic m_update(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tg);
      int f;
      f = m_find(pc);
      if (f >= 0) m_remove(f);
      if (tk) begin
         if (m_cnt == NE) m_cnt--;
         for (int i = m_cnt; i > 0; i--) begin
            m_pc[i]  = m_pc[i-1];
            m_tgt[i] = m_tgt[i-1];
         end
         m_pc[0]  = pc;
         m_tgt[0] = tg;
         m_cnt++;
      end
   endtask

   task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Combinational lookup probe; call between clock edges with no update pending.
   task automatic probe(logic [AW-1:0] addr, string req);
      int f;
      logic          eh;
      logic [AW-1:0] en;
      f = -1;
      for (int i = 0; i < m_cnt; i++) if (m_pc[i] - 32'd4 == addr) f = i;
      eh = (f >= 0);
      en = eh ? m_tgt[f] : addr + 32'd4;
      fetch_addr = addr;
      #1;
      chk(pred_hit == eh, {req, " hit"}, AW'(pred_hit), AW'(eh));
      chk(pred_next == en, {req, " next"}, pred_next, en);
   endtask

   task automatic probe_all(string req);
      for (int b = 0; b < NB; b++) probe(pc_of(b) - 32'd4, req);
   endtask

   task automatic resolve(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tg,
                          bit ptk, logic [AW-1:0] ptg);
      logic          em;
      logic [AW-1:0] er;
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
      upd_pred_taken = ptk; upd_pred_target = ptg;
      @(negedge clk);
      upd_valid = 1'b0;
      em = (tk != ptk) || (tk && ptk && tg != ptg);
      er = tk ? tg : pc + 32'd4;
      #1;
      chk(mispredict == em, "R10 mispredict", AW'(mispredict), AW'(em));
      if (em) chk(redirect_addr == er, "R10 redirect", redirect_addr, er);
      m_update(pc, tk, tg);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty after reset; R3 sequential next
      probe_all("R1");
      probe(32'h0000_0ffc, "R3");
      @(negedge clk);
      #1;
      chk(mispredict == 1'b0, "R10 idle", AW'(mispredict), 32'd0);

      // R5: not-taken of unknown branch allocates nothing
      resolve(pc_of(0), 1'b0, tgt_of(0, 0), 1'b0, '0);
      probe_all("R5");

      // R4 / R2: allocate four taken branches
      for (int b = 0; b < NE; b++) resolve(pc_of(b), 1'b1, tgt_of(b, 0), 1'b0, '0);
      probe_all("R4");
      probe(pc_of(1), "R2 own-address");

      // R7: retarget in place
      resolve(pc_of(2), 1'b1, tgt_of(2, 1), 1'b1, tgt_of(2, 0));
      probe(pc_of(2) - 32'd4, "R7");

      // R8: refresh branch 0, then a new branch evicts branch 1
      resolve(pc_of(0), 1'b1, tgt_of(0, 0), 1'b1, tgt_of(0, 0));
      resolve(pc_of(4), 1'b1, tgt_of(4, 0), 1'b0, '0);
      probe_all("R8 evict");
      probe(pc_of(1) - 32'd4, "R8 lru-gone");

      // R6: drop branch 3; R8: next allocation fills the hole
      resolve(pc_of(3), 1'b0, '0, 1'b1, tgt_of(3, 0));
      probe(pc_of(3) - 32'd4, "R6");
      resolve(pc_of(5), 1'b1, tgt_of(5, 0), 1'b0, '0);
      probe_all("R8 hole");

      // R9: update and lookup of the same key in one cycle
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc_of(6); upd_taken = 1'b1; upd_target = tgt_of(6, 2);
      upd_pred_taken = 1'b0; upd_pred_target = '0;
      fetch_addr = pc_of(6) - 32'd4;
      #1;
      chk(pred_hit == 1'b1, "R9 hit", AW'(pred_hit), 32'd1);
      chk(pred_next == tgt_of(6, 2), "R9 next", pred_next, tgt_of(6, 2));
      @(negedge clk);
      upd_valid = 1'b0;
      m_update(pc_of(6), 1'b1, tgt_of(6, 2));
      #1;
      chk(mispredict == 1'b1, "R10 alloc", AW'(mispredict), 32'd1);
      probe_all("R9 after");

      // Sweep: pseudo-random resolutions against the reference list
      lfsr = 16'hACE1;
      for (int s = 0; s < 300; s++) begin
         int            b, f;
         bit            tk, ptk;
         logic [AW-1:0] tg, ptg;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         b  = int'(lfsr[2:0]);
         tk = (lfsr[5:4] != 2'b00);
         tg = tgt_of(b, int'(lfsr[7]));
         f  = m_find(pc_of(b));
         ptk = (f >= 0);
         ptg = ptk ? m_tgt[f] : '0;
         if (s % 7 == 3) ptk = ~ptk;
         resolve(pc_of(b), tk, tg, ptk, ptg);
         probe_all("R8 sweep");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule